// File: doc/BRIEF.md
# ECC Register File with One-Shot Fault Injection

This block is a multi-ported register file whose every entry carries a SECDED code. It has one write port and two independent read ports, A and B. Each word is stored with seven check bits: six Hamming bits and one overall parity bit over the whole codeword. Each read port decodes the stored codeword. A single-bit fault is corrected on the returned data and flagged as correctable. A double-bit fault is flagged as uncorrectable.

A two-bit injection control field lets software test the error path. Software arms the field with a single-bit or a double-bit mode. The next write to any entry other than entry 0 is then stored with data bit 0 flipped (single mode) or data bits 0 and 1 flipped (double mode). The check bits are computed from the uncorrupted data. That write consumes the arming: the field drops back to the off value by itself, and the off value can be read back on the mode output. No error shows when the write happens. The error is reported only when the corrupted entry is later read, and it is reported on whichever read port reads it.

Entry 0 is a constant zero. Writes to it are discarded, and reads of it never flag an error.

Top module: `ecc_regfile`

## Requirements
- R1: After reset, every entry reads as zero with no error flag, both read ports show valid, data, correctable and uncorrectable all low, and the injection mode reads 2'b00.
- R2: A read on either port with its enable high returns, one cycle later, the last data written to that entry, with the valid output high for that one cycle.
- R3: Writes to entry 0 are discarded. A read of entry 0 returns zero with both error flags low.
- R4: A control write loads the two-bit injection mode, which appears on the mode output one cycle later. The encodings are 2'b00 off, 2'b01 single-bit and 2'b10 double-bit.
- R5: A write made in single-bit mode stores data bit 0 inverted. A later read of that entry on port A or port B returns the original data, corrected, with that port's correctable flag high for one cycle.
- R6: A write made in double-bit mode stores data bits 0 and 1 inverted. A later read of that entry on either port raises that port's uncorrectable flag for one cycle and returns the stored data uncorrected, that is, the written data XOR 3.
- R7: The write that carries an injection returns the mode to 2'b00 in the next cycle. Later writes are stored clean, and rewriting a corrupted entry removes its error.
- R8: While single-bit or double-bit mode is armed, a write to entry 0 neither consumes the mode nor corrupts anything.
- R9: Mode 2'b11 injects nothing, is never consumed by a write and reads back as 2'b11.
- R10: When a control write and a data write fall in the same cycle, the data write uses the mode held before that cycle, and the mode then takes the control-written value.
- R11: Error flags are raised only in the cycle after a read enable. A corrupting write raises no flag on either port.
- R12: A read of an entry in the same cycle as a write to it returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write entry index |
| wr_data | input | 32 | Write data |
| inj_we | input | 1 | Injection control write strobe |
| inj_mode_in | input | 2 | Injection mode to load |
| inj_mode | output | 2 | Current injection mode (readback) |
| ra_en | input | 1 | Port A read enable |
| ra_addr | input | 5 | Port A entry index |
| ra_data | output | 32 | Port A read data (corrected) |
| ra_valid | output | 1 | Port A result valid |
| ra_ce | output | 1 | Port A correctable-error pulse |
| ra_ue | output | 1 | Port A uncorrectable-error pulse |
| rb_en | input | 1 | Port B read enable |
| rb_addr | input | 5 | Port B entry index |
| rb_data | output | 32 | Port B read data (corrected) |
| rb_valid | output | 1 | Port B result valid |
| rb_ce | output | 1 | Port B correctable-error pulse |
| rb_ue | output | 1 | Port B uncorrectable-error pulse |

## Verification
A read result and its error flags are registered, so they are due exactly one cycle after the read enable. The injection mode output changes one cycle after a control write or after a consuming write. The bench drives each stimulus on the falling edge. At that moment its model computes the expected read result and pushes it into that port's queue. A monitor then compares the queue entry with the port outputs on the next falling edge, which is one cycle after the enable. Flags seen in any cycle without a valid result, and results with no queued expectation, count as failures. The mode output is compared with the model one cycle after each stimulus.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

   typedef enum logic [1:0] {
      INJ_OFF = 2'b00,
      INJ_ONE = 2'b01,
      INJ_TWO = 2'b10,
      INJ_RSV = 2'b11
   } inj_mode_e;

   // Number of Hamming bits needed to cover d data bits.
   function automatic int hamm_bits(input int d);
      int r;
      r = 0;
      for (int k = 0; k < 16; k++) begin
         if ((1 << r) < d + r + 1) r++;
      end
      return r;
   endfunction

   // One-based codeword position of data bit i (powers of two are check bits).
   function automatic int data_pos(input int i);
      int cnt;
      cnt = -1;
      for (int k = 1; k < 1024; k++) begin
         if ((k & (k - 1)) != 0) begin
            cnt++;
            if (cnt == i) return k;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/ecc_rf_enc.sv
module ecc_rf_enc
   import ecc_rf_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HB_W  = hamm_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [HB_W-1:0]   hamm_o,
   output logic              par_o
);

   function automatic logic [DATA_W-1:0] cover_mask(input int j);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (((data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
      end
      return m;
   endfunction

   for (genvar j = 0; j < HB_W; j++) begin : g_hamm
      localparam logic [DATA_W-1:0] COVER = cover_mask(j);
      assign hamm_o[j] = ^(data_i & COVER);
   end

   assign par_o = (^data_i) ^ (^hamm_o);

endmodule

// File: rtl/ecc_rf_dec.sv
module ecc_rf_dec
   import ecc_rf_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HB_W  = hamm_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [HB_W-1:0]   hamm_i,
   input  logic              par_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ce_o,
   output logic              ue_o
);

   logic [HB_W-1:0]   hamm_re;
   logic              par_re;
   logic [HB_W-1:0]   syndrome;
   logic              odd;
   logic [DATA_W-1:0] fix;

   ecc_rf_enc #(.DATA_W(DATA_W)) u_re (
      .data_i (data_i),
      .hamm_o (hamm_re),
      .par_o  (par_re)
   );

   assign syndrome = hamm_i ^ hamm_re;
   // overall parity of the received codeword
   assign odd      = par_i ^ par_re ^ (^syndrome);
   assign ce_o     = odd;
   assign ue_o     = !odd && (syndrome != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam logic [HB_W-1:0] POS = HB_W'(data_pos(i));
      assign fix[i] = odd && (syndrome == POS);
   end

   assign data_o = data_i ^ fix;

endmodule

// File: rtl/ecc_rf_rdport.sv
module ecc_rf_rdport
   import ecc_rf_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HB_W  = hamm_bits(DATA_W),
   localparam int CW_W  = DATA_W + HB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              zero_i,
   input  logic [CW_W-1:0]   word_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              ce_o,
   output logic              ue_o
);

   logic [DATA_W-1:0] dec_data;
   logic              dec_ce;
   logic              dec_ue;

   ecc_rf_dec #(.DATA_W(DATA_W)) u_dec (
      .data_i (word_i[DATA_W-1:0]),
      .hamm_i (word_i[DATA_W +: HB_W]),
      .par_i  (word_i[CW_W-1]),
      .data_o (dec_data),
      .ce_o   (dec_ce),
      .ue_o   (dec_ue)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
         ce_o    <= 1'b0;
         ue_o    <= 1'b0;
      end else begin
         valid_o <= en_i;
         ce_o    <= en_i && !zero_i && dec_ce;
         ue_o    <= en_i && !zero_i && dec_ue;
         if (en_i) data_o <= zero_i ? '0 : dec_data;
      end
   end

endmodule

// File: rtl/ecc_rf_injctl.sv
module ecc_rf_injctl
   import ecc_rf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we_i,
   input  logic [1:0] ctl_mode_i,
   input  logic       wr_hit_i,
   output logic [1:0] mode_o,
   output logic [1:0] flip_o
);

   inj_mode_e mode_q;
   logic      consume;

   always_comb begin
      unique case (mode_q)
         INJ_ONE: flip_o = 2'b01;
         INJ_TWO: flip_o = 2'b11;
         default: flip_o = 2'b00;
      endcase
   end

   assign consume = wr_hit_i && (flip_o != 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n)        mode_q <= INJ_OFF;
      else if (ctl_we_i) mode_q <= inj_mode_e'(ctl_mode_i);
      else if (consume)  mode_q <= INJ_OFF;
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
   import ecc_rf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int HB_W   = hamm_bits(DATA_W),
   localparam int CW_W   = DATA_W + HB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              inj_we,
   input  logic [1:0]        inj_mode_in,
   output logic [1:0]        inj_mode,
   input  logic              ra_en,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   output logic              ra_valid,
   output logic              ra_ce,
   output logic              ra_ue,
   input  logic              rb_en,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data,
   output logic              rb_valid,
   output logic              rb_ce,
   output logic              rb_ue
);

   if (DATA_W < 2 || DATA_W > 120) begin : g_bad_width
      $error("ecc_regfile: DATA_W must lie in 2..120");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("ecc_regfile: DEPTH must be a power of two of at least 2");
   end

   logic [CW_W-1:0]   mem [DEPTH];
   logic              wr_ok;
   logic [1:0]        flip;
   logic [HB_W-1:0]   enc_hamm;
   logic              enc_par;
   logic [DATA_W-1:0] store_data;

   assign wr_ok = wr_en && (wr_addr != '0);

   ecc_rf_injctl u_inj (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we_i   (inj_we),
      .ctl_mode_i (inj_mode_in),
      .wr_hit_i   (wr_ok),
      .mode_o     (inj_mode),
      .flip_o     (flip)
   );

   // check bits always come from the clean data; injection corrupts the stored data
   ecc_rf_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (wr_data),
      .hamm_o (enc_hamm),
      .par_o  (enc_par)
   );

   assign store_data = wr_data ^ {{(DATA_W-2){1'b0}}, flip};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
      end else if (wr_ok) begin
         mem[wr_addr] <= {enc_par, enc_hamm, store_data};
      end
   end

   ecc_rf_rdport #(.DATA_W(DATA_W)) u_rda (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (ra_en),
      .zero_i  (ra_addr == '0),
      .word_i  (mem[ra_addr]),
      .data_o  (ra_data),
      .valid_o (ra_valid),
      .ce_o    (ra_ce),
      .ue_o    (ra_ue)
   );

   ecc_rf_rdport #(.DATA_W(DATA_W)) u_rdb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (rb_en),
      .zero_i  (rb_addr == '0),
      .word_i  (mem[rb_addr]),
      .data_o  (rb_data),
      .valid_o (rb_valid),
      .ce_o    (rb_ce),
      .ue_o    (rb_ue)
   );

endmodule

// File: rtl/ecc_rf_chk.sv
module ecc_rf_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              inj_we,
   input logic [1:0]        inj_mode_in,
   input logic [1:0]        inj_mode,
   input logic              ra_en,
   input logic [ADDR_W-1:0] ra_addr,
   input logic [DATA_W-1:0] ra_data,
   input logic              ra_valid,
   input logic              ra_ce,
   input logic              ra_ue,
   input logic              rb_en,
   input logic [ADDR_W-1:0] rb_addr,
   input logic [DATA_W-1:0] rb_data,
   input logic              rb_valid,
   input logic              rb_ce,
   input logic              rb_ue
);

   p_valid_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ra_en |=> ra_valid);
   p_valid_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rb_en |=> rb_valid);

   p_zero_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_en && ra_addr == '0) |=> (ra_data == '0 && !ra_ce && !ra_ue));
   p_zero_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_en && rb_addr == '0) |=> (rb_data == '0 && !rb_ce && !rb_ue));

   p_ctl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      inj_we |=> inj_mode == $past(inj_mode_in));

   p_flags_excl_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ra_ce && ra_ue));
   p_flags_excl_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rb_ce && rb_ue));

   p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_we && wr_en && wr_addr != '0 && (inj_mode == 2'b01 || inj_mode == 2'b10))
      |=> inj_mode == 2'b00);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_we && (!wr_en || wr_addr == '0)) |=> $stable(inj_mode));

   p_rsv_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_we && inj_mode == 2'b11) |=> inj_mode == 2'b11);

   p_flag_needs_read_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_ce || ra_ue) |-> ra_valid);
   p_flag_needs_read_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_ce || rb_ue) |-> rb_valid);

endmodule

bind ecc_regfile ecc_rf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .inj_we      (inj_we),
   .inj_mode_in (inj_mode_in),
   .inj_mode    (inj_mode),
   .ra_en       (ra_en),
   .ra_addr     (ra_addr),
   .ra_data     (ra_data),
   .ra_valid    (ra_valid),
   .ra_ce       (ra_ce),
   .ra_ue       (ra_ue),
   .rb_en       (rb_en),
   .rb_addr     (rb_addr),
   .rb_data     (rb_data),
   .rb_valid    (rb_valid),
   .rb_ce       (rb_ce),
   .rb_ue       (rb_ue)
);

// File: tb/sim_ecc_regfile.sv
module sim_ecc_regfile;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, inj_we, ra_en, rb_en;
   logic [4:0]  wr_addr, ra_addr, rb_addr;
   logic [31:0] wr_data;
   logic [1:0]  inj_mode_in, inj_mode;
   logic [31:0] ra_data, rb_data;
   logic        ra_valid, ra_ce, ra_ue, rb_valid, rb_ce, rb_ue;

   int tests = 0;
   int fails = 0;

   // model state
   logic [31:0] m_val [32];
   int          m_err [32];
   logic [1:0]  m_mode;

   // scoreboards: {ue, ce, data}
   logic [33:0] qa[$], qb[$];
   string       qa_tag[$], qb_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_regfile u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inj_we(inj_we), .inj_mode_in(inj_mode_in), .inj_mode(inj_mode),
      .ra_en(ra_en), .ra_addr(ra_addr), .ra_data(ra_data),
      .ra_valid(ra_valid), .ra_ce(ra_ce), .ra_ue(ra_ue),
      .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data),
      .rb_valid(rb_valid), .rb_ce(rb_ce), .rb_ue(rb_ue)
   );

   task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [33:0] expect_read(int a);
      if (a == 0) return '0;
      case (m_err[a])
         1:       return {2'b01, m_val[a]};
         2:       return {2'b10, m_val[a] ^ 32'h3};
         default: return {2'b00, m_val[a]};
      endcase
   endfunction

   // one cycle of stimulus, driven at a falling edge
   task automatic tick(bit we, int wa, logic [31:0] wd, bit cwe, logic [1:0] cm,
                       bit ae, int aa, bit be, int ba, string tag);
      logic [1:0] cur;
      if (ae) begin qa.push_back(expect_read(aa)); qa_tag.push_back(tag); end
      if (be) begin qb.push_back(expect_read(ba)); qb_tag.push_back(tag); end
      wr_en = we; wr_addr = 5'(wa); wr_data = wd;
      inj_we = cwe; inj_mode_in = cm;
      ra_en = ae; ra_addr = 5'(aa); rb_en = be; rb_addr = 5'(ba);
      cur = m_mode;
      if (we && wa != 0) begin
         m_val[wa] = wd;
         m_err[wa] = (cur == 2'b01) ? 1 : (cur == 2'b10) ? 2 : 0;
      end
      if (cwe) m_mode = cm;
      else if (we && wa != 0 && (cur == 2'b01 || cur == 2'b10)) m_mode = 2'b00;
      @(negedge clk);
      wr_en = 0; inj_we = 0; ra_en = 0; rb_en = 0;
      chk({tag, " mode"}, {32'b0, inj_mode}, {32'b0, m_mode});
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ra_valid) begin
            if (qa.size() == 0) chk("R2 unexpected A result", 34'h1, 34'h0);
            else chk({qa_tag.pop_front(), " port A"}, {ra_ue, ra_ce, ra_data}, qa.pop_front());
         end else if (ra_ce || ra_ue) chk("R11 port A flag without read", {ra_ue, ra_ce, 32'b0}, '0);
         if (rb_valid) begin
            if (qb.size() == 0) chk("R2 unexpected B result", 34'h1, 34'h0);
            else chk({qb_tag.pop_front(), " port B"}, {rb_ue, rb_ce, rb_data}, qb.pop_front());
         end else if (rb_ce || rb_ue) chk("R11 port B flag without read", {rb_ue, rb_ce, 32'b0}, '0);
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin m_val[i] = '0; m_err[i] = 0; end
      m_mode = 2'b00;
      rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; inj_we = 0; inj_mode_in = 0;
      ra_en = 0; ra_addr = 0; rb_en = 0; rb_addr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state of outputs
      chk("R1 port A outputs", {ra_ue, ra_ce, ra_data}, '0);
      chk("R1 port B outputs", {rb_ue, rb_ce, rb_data}, '0);
      chk("R1 valid", {32'b0, ra_valid, rb_valid}, '0);
      chk("R1 mode", {32'b0, inj_mode}, '0);
      tick(0, 0, 0, 0, 0, 1, 3, 1, 31, "R1 entries cleared");
      // R2: plain writes and reads on both ports
      tick(1, 5, 32'hA5A5_5A5A, 0, 0, 0, 0, 0, 0, "R2 write");
      tick(1, 31, 32'hFFFF_FFFF, 0, 0, 1, 5, 0, 0, "R2 write/read");
      tick(1, 1, 32'h0000_0001, 0, 0, 1, 31, 1, 5, "R2 read");
      tick(0, 0, 0, 0, 0, 1, 1, 1, 31, "R2 read");
      // R3: entry 0
      tick(1, 0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R3 write zero");
      tick(0, 0, 0, 0, 0, 1, 0, 1, 0, "R3 read zero");
      // R4 arm single, R8 entry-0 write does not consume
      tick(0, 0, 0, 1, 2'b01, 0, 0, 0, 0, "R4 arm single");
      tick(1, 0, 32'h7, 0, 0, 0, 0, 0, 0, "R8 zero write keeps arm");
      chk("R8 still armed", {32'b0, inj_mode}, {32'b0, 2'b01});
      // R5/R7/R12/R11: corrupting write, same-cycle read of old value
      tick(1, 7, 32'h0F0F_1234, 0, 0, 1, 7, 0, 0, "R12 old value");
      chk("R7 disarmed", {32'b0, inj_mode}, '0);
      idle(2);
      tick(0, 0, 0, 0, 0, 1, 7, 0, 0, "R5 single on A");
      tick(0, 0, 0, 0, 0, 0, 0, 1, 7, "R5 single on B");
      tick(1, 8, 32'hCAFE_0003, 0, 0, 1, 8, 1, 8, "R7 clean write");
      tick(0, 0, 0, 0, 0, 1, 8, 1, 8, "R7 clean read");
      // R6: double-bit injection
      tick(0, 0, 0, 1, 2'b10, 0, 0, 0, 0, "R4 arm double");
      tick(1, 9, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R6 write");
      tick(0, 0, 0, 0, 0, 1, 9, 1, 9, "R6 double on both");
      chk("R6 raw data", {2'b0, ra_data}, {2'b0, 32'h1234_567B});
      // R7: rewriting a corrupted entry clears it
      tick(1, 7, 32'h0F0F_1234, 0, 0, 0, 0, 0, 0, "R7 rewrite");
      tick(0, 0, 0, 0, 0, 1, 7, 1, 9, "R7 rewritten");
      // R9: reserved mode
      tick(0, 0, 0, 1, 2'b11, 0, 0, 0, 0, "R9 arm reserved");
      tick(1, 10, 32'h5555_AAAA, 0, 0, 0, 0, 0, 0, "R9 write");
      chk("R9 kept", {32'b0, inj_mode}, {32'b0, 2'b11});
      tick(0, 0, 0, 0, 0, 1, 10, 1, 10, "R9 clean");
      // R10: control write and data write in the same cycle
      tick(0, 0, 0, 1, 2'b01, 0, 0, 0, 0, "R10 arm single");
      tick(1, 11, 32'h0000_00F0, 1, 2'b10, 0, 0, 0, 0, "R10 collide");
      chk("R10 ctl wins", {32'b0, inj_mode}, {32'b0, 2'b10});
      tick(1, 12, 32'h8000_0000, 0, 0, 1, 11, 0, 0, "R10 old mode used");
      tick(0, 0, 0, 0, 0, 0, 0, 1, 12, "R10 new mode used");
      idle(3);
      chk("R2 queues drained", {32'b0, 1'b0, (qa.size() + qb.size()) != 0}, '0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule